// File: doc/BRIEF.md
# Data Cache Line Maintenance Unit

This unit carries out per-line maintenance commands on a small write-back data cache whose lines are 128 bytes long. An already decoded 32-bit instruction word arrives with the values of its two source registers. The unit forms an effective address and checks the line it selects. It then runs one of four operations: flush (write back if dirty, then drop the line), write-back only (keep the line, make it clean), discard (drop the line and lose any dirty data; this one is privileged) and zero-allocate (claim the line as dirty zeros without reading memory).

The cache is direct-mapped with eight lines, and the unit keeps a tag, a valid bit and a dirty bit for each one. Line data belongs to the surrounding datapath, so a write-back is presented as a line address on a memory write port. That port stays asserted for a fixed number of cycles. A translation-fault input and the user/supervisor mode arrive with each command. A command can end in a data-storage fault or a privilege fault, and in either case the cache is left untouched. The unit orders no other memory traffic: done means only that the line operation has finished.

Top module: `cline_maint`

## Requirements
- R1: A command is recognised only when instr[31:26] equals 31. The 10-bit extended field instr[10:1] then selects the operation: 86 flush, 54 write-back only, 470 discard, 1014 zero-allocate. Any other word completes with done, changes no line, writes no memory and raises no fault.
- R2: The effective address is rb_val plus a base. The base is the 64-bit value zero when the register number in instr[20:16] is 0, and ra_val otherwise. Address bits 6:0 are ignored, bits 9:7 index the line and bits 63:10 form the tag. mem_wr_addr carries address bits 63:7 of the line being written.
- R3: A flush that hits a dirty line holds mem_wr_en high for exactly 4 cycles with that line's address, then invalidates the line.
- R4: A flush that hits a clean line invalidates it without any memory write. A flush that misses does nothing.
- R5: A write-back-only command on a dirty hit writes the line back and leaves it valid and clean, so a later flush or write-back of it makes no write. On a clean hit or a miss it writes nothing.
- R6: Discard invalidates a hit line without writing it back. In user mode (cmd_user=1) it is rejected with fault_priv and the cache stays unchanged.
- R7: When xlate_fault is high with an accepted recognised command, the command ends with fault_dsi, makes no write and changes no line. A privilege rejection takes priority, so fault_dsi stays low when fault_priv is raised. Faults appear only in the done cycle.
- R8: Zero-allocate makes the line valid and dirty under the new tag. If the indexed slot holds a dirty line with another tag, that victim is written back first at its own address. A hit or a clean victim causes no write.
- R9: busy is high from the cycle after a command is accepted through its done cycle. done is a single-cycle pulse, 2 cycles after acceptance without a write-back and 6 cycles after with one. cmd_valid is ignored while busy.
- R10: During and after reset, busy, done, both faults and mem_wr_en are low and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; accepted when not busy |
| cmd_instr | input | 32 | Decoded instruction word |
| cmd_ra_val | input | 64 | Value of the base register |
| cmd_rb_val | input | 64 | Value of the index register |
| cmd_user | input | 1 | Command issued in user mode |
| xlate_fault | input | 1 | Address translation fails for this command |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| fault_dsi | output | 1 | Data-storage fault, valid with done |
| fault_priv | output | 1 | Privilege fault, valid with done |
| mem_wr_en | output | 1 | Line write-back in progress |
| mem_wr_addr | output | 57 | Line address being written back |

## Verification
The bench reaches the same line with differing offsets and with a nonzero base value under register number 0. A design that added the base there, or kept the offset bits, would miss the line and lose an expected write-back. Faulted and privilege-rejected commands are followed by a flush of the same line, so a design that changed state on a fault shows a missing write. A zero-allocate onto a dirty line with another tag must write back the old address, not the new one. Discarded dirty data, the clean state after a write-back, a command poked in while busy, and a reset in the middle of use are each followed by a flush that must not write. A design that kept the wrong state would produce a stray write.

// File: rtl/cline_pkg.sv
package cline_pkg;

  localparam logic [5:0] PRIM_OP  = 6'd31;
  localparam logic [9:0] XO_FLUSH = 10'd86;
  localparam logic [9:0] XO_CLEAN = 10'd54;
  localparam logic [9:0] XO_DROP  = 10'd470;
  localparam logic [9:0] XO_ZERO  = 10'd1014;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_FLUSH = 3'd1,
    OP_CLEAN = 3'd2,
    OP_DROP  = 3'd3,
    OP_ZERO  = 3'd4
  } line_op_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_WB   = 2'd2,
    ST_FIN  = 2'd3
  } ctl_state_t;

endpackage

// File: rtl/cline_decode.sv
module cline_decode
  import cline_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [31:0]       instr,
  input  logic [ADDR_W-1:0] ra_val,
  input  logic [ADDR_W-1:0] rb_val,
  output line_op_t          op,
  output logic [ADDR_W-1:0] ea
);

  logic [5:0]        prim;
  logic [9:0]        xo;
  logic [4:0]        ra_num;
  logic [ADDR_W-1:0] base;

  assign prim   = instr[31:26];
  assign ra_num = instr[20:16];
  assign xo     = instr[10:1];

  // a zero register number means a literal zero base
  assign base = (ra_num == 5'd0) ? '0 : ra_val;
  assign ea   = base + rb_val;

  always_comb begin
    op = OP_NONE;
    if (prim == PRIM_OP) begin
      unique case (xo)
        XO_FLUSH: op = OP_FLUSH;
        XO_CLEAN: op = OP_CLEAN;
        XO_DROP:  op = OP_DROP;
        XO_ZERO:  op = OP_ZERO;
        default:  op = OP_NONE;
      endcase
    end
  end

  logic unused_bits;
  assign unused_bits = ^{instr[25:21], instr[15:11], instr[0]};

endmodule

// File: rtl/cline_store.sv
module cline_store #(
  parameter int LINES = 8,
  parameter int TAG_W = 54,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             upd_en,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic             upd_valid,
  input  logic             upd_dirty
);

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic sel;
    assign sel = upd_en && (rd_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
        tag_q[g]   <= '0;
      end else if (sel) begin
        valid_q[g] <= upd_valid;
        dirty_q[g] <= upd_dirty;
        tag_q[g]   <= upd_tag;
      end
    end

    // R8
    dirty_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dirty_q[g] |-> valid_q[g]);
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/cline_wbseq.sv
module cline_wbseq #(
  parameter int WB_CYCLES = 4,
  parameter int LADDR_W   = 57,
  localparam int CNT_W    = $clog2(WB_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LADDR_W-1:0] start_addr,
  output logic               last,
  output logic               wr_en,
  output logic [LADDR_W-1:0] wr_addr
);

  logic               act_q, act_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [LADDR_W-1:0] addr_q;
  logic               addr_en;

  assign last    = act_q && (cnt_q == CNT_W'(WB_CYCLES - 1));
  assign addr_en = start && !act_q;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (addr_en) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (act_q) begin
      if (last) act_d = 1'b0;
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= start_addr;
  end

  assign wr_en   = act_q;
  assign wr_addr = addr_q;

  // R3
  wb_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cnt_q < CNT_W'(WB_CYCLES)));

  // R3
  wb_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!wr_en || $stable(wr_addr)));

endmodule

// File: rtl/cline_maint.sv
module cline_maint
  import cline_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LINE_BYTES = 128,
  parameter int LINES      = 8,
  parameter int WB_CYCLES  = 4,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = $clog2(LINES),
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
  localparam int LADDR_W   = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [31:0]        cmd_instr,
  input  logic [ADDR_W-1:0]  cmd_ra_val,
  input  logic [ADDR_W-1:0]  cmd_rb_val,
  input  logic               cmd_user,
  input  logic               xlate_fault,
  output logic               busy,
  output logic               done,
  output logic               fault_dsi,
  output logic               fault_priv,
  output logic               mem_wr_en,
  output logic [LADDR_W-1:0] mem_wr_addr
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  // decode
  line_op_t          dec_op;
  logic [ADDR_W-1:0] dec_ea;

  cline_decode #(.ADDR_W(ADDR_W)) u_dec (
    .instr  (cmd_instr),
    .ra_val (cmd_ra_val),
    .rb_val (cmd_rb_val),
    .op     (dec_op),
    .ea     (dec_ea)
  );

  // command registers
  ctl_state_t       state_q, state_d;
  line_op_t         op_q;
  logic [TAG_W-1:0] tag_q;
  logic [IDX_W-1:0] idx_q;
  logic             fpriv_q, fdsi_q;
  logic             accept;

  assign accept = cmd_valid && (state_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      op_q    <= OP_NONE;
      tag_q   <= '0;
      idx_q   <= '0;
      fpriv_q <= 1'b0;
      fdsi_q  <= 1'b0;
    end else if (accept) begin
      op_q    <= dec_op;
      tag_q   <= dec_ea[ADDR_W-1 -: TAG_W];
      idx_q   <= dec_ea[OFF_W +: IDX_W];
      fpriv_q <= (dec_op == OP_DROP) && cmd_user;
      fdsi_q  <= (dec_op != OP_NONE) && xlate_fault
                 && !((dec_op == OP_DROP) && cmd_user);
    end
  end

  logic unused_off;
  assign unused_off = ^dec_ea[OFF_W-1:0];

  // line state
  logic             ln_valid, ln_dirty;
  logic [TAG_W-1:0] ln_tag;
  logic             upd_en, upd_valid, upd_dirty;
  logic [TAG_W-1:0] upd_tag;

  cline_store #(.LINES(LINES), .TAG_W(TAG_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .rd_idx    (idx_q),
    .rd_valid  (ln_valid),
    .rd_dirty  (ln_dirty),
    .rd_tag    (ln_tag),
    .upd_en    (upd_en),
    .upd_tag   (upd_tag),
    .upd_valid (upd_valid),
    .upd_dirty (upd_dirty)
  );

  // action decision (stable from EXEC through WB)
  logic               hit, faulted, need_wb, do_upd;
  logic [LADDR_W-1:0] wb_addr;

  assign hit     = ln_valid && (ln_tag == tag_q);
  assign faulted = fpriv_q || fdsi_q;

  always_comb begin
    need_wb   = 1'b0;
    do_upd    = 1'b0;
    wb_addr   = {tag_q, idx_q};
    upd_tag   = ln_tag;
    upd_valid = ln_valid;
    upd_dirty = ln_dirty;
    unique case (op_q)
      OP_FLUSH: begin
        need_wb   = hit && ln_dirty;
        do_upd    = hit;
        upd_valid = 1'b0;
        upd_dirty = 1'b0;
      end
      OP_CLEAN: begin
        need_wb   = hit && ln_dirty;
        do_upd    = hit && ln_dirty;
        upd_dirty = 1'b0;
      end
      OP_DROP: begin
        do_upd    = hit;
        upd_valid = 1'b0;
        upd_dirty = 1'b0;
      end
      OP_ZERO: begin
        need_wb   = ln_valid && ln_dirty && !hit;
        wb_addr   = {ln_tag, idx_q};
        do_upd    = 1'b1;
        upd_tag   = tag_q;
        upd_valid = 1'b1;
        upd_dirty = 1'b1;
      end
      default: ;
    endcase
  end

  // write-back sequencer
  logic wb_start, wb_last;

  assign wb_start = (state_q == ST_EXEC) && !faulted && need_wb;

  cline_wbseq #(.WB_CYCLES(WB_CYCLES), .LADDR_W(LADDR_W)) u_wb (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .start      (wb_start),
    .start_addr (wb_addr),
    .last       (wb_last),
    .wr_en      (mem_wr_en),
    .wr_addr    (mem_wr_addr)
  );

  assign upd_en = do_upd && !faulted &&
                  (((state_q == ST_EXEC) && !need_wb) ||
                   ((state_q == ST_WB) && wb_last));

  // control state machine
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_EXEC;
      ST_EXEC: state_d = wb_start ? ST_WB : ST_FIN;
      ST_WB:   if (wb_last) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_FIN);
  assign fault_priv = done && fpriv_q;
  assign fault_dsi  = done && fdsi_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    done |=> !done);

  // R9
  wr_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    mem_wr_en |-> (busy && !done));

  // R7
  fault_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (fault_dsi || fault_priv) |-> (done && !(fault_dsi && fault_priv)));

  // R7
  fault_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (state_q == ST_EXEC && faulted) |=> (!mem_wr_en && done));

  // R9
  exec_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    accept |=> (state_q == ST_EXEC));

endmodule

// File: tb/cline_maint_test.sv
module cline_maint_test;

  typedef struct packed {
    logic [5:0]  prim;
    logic [9:0]  xo;
    logic [4:0]  ran;
    logic [63:0] ra;
    logic [63:0] rb;
    logic        usr;
    logic        xf;
    logic        wr;
    logic [56:0] wa;
    logic        dsi;
    logic        prv;
  } vec_t;

  localparam logic [9:0] FL = 10'd86, CL = 10'd54, DR = 10'd470, ZR = 10'd1014;
  localparam int NV = 21;

  localparam vec_t VEC [NV] = '{
    '{6'd31, ZR, 5'd0, 64'h0,         64'h1000, 1'b0, 1'b0, 1'b0, 57'h0,  1'b0, 1'b0},
    '{6'd31, FL, 5'd3, 64'h1000,      64'h45,   1'b0, 1'b0, 1'b1, 57'h20, 1'b0, 1'b0},
    '{6'd31, FL, 5'd0, 64'h0,         64'h1000, 1'b0, 1'b0, 1'b0, 57'h0,  1'b0, 1'b0},
    '{6'd31, ZR, 5'd0, 64'hFFFF0000,  64'h1080, 1'b0, 1'b0, 1'b0, 57'h0,  1'b0, 1'b0},
    '{6'd31, CL, 5'd0, 64'h0,         64'h10FF, 1'b0, 1'b0, 1'b1, 57'h21, 1'b0, 1'b0},
    '{6'd31, CL, 5'd0, 64'h0,         64'h1080, 1'b0, 1'b0, 1'b0, 57'h0,  1'b0, 1'b0},
    '{6'd31, FL, 5'd0, 64'h0,         64'h1080, 1'b0, 1'b0, 1'b0, 57'h0,  1'b0, 1'b0},
    '{6'd31, ZR, 5'd0, 64'h0,         64'h2000, 1'b0, 1'b0, 1'b0, 57'h0,  1'b0, 1'b0},
    '{6'd31, ZR, 5'd0, 64'h0,         64'h3000, 1'b0, 1'b0, 1'b1, 57'h40, 1'b0, 1'b0},
    '{6'd31, ZR, 5'd0, 64'h0,         64'h3010, 1'b0, 1'b0, 1'b0, 57'h0,  1'b0, 1'b0},
    '{6'd31, DR, 5'd0, 64'h0,         64'h3000, 1'b1, 1'b0, 1'b0, 57'h0,  1'b0, 1'b1},
    '{6'd31, FL, 5'd0, 64'h0,         64'h3000, 1'b1, 1'b1, 1'b0, 57'h0,  1'b1, 1'b0},
    '{6'd31, FL, 5'd0, 64'h0,         64'h3000, 1'b1, 1'b0, 1'b1, 57'h60, 1'b0, 1'b0},
    '{6'd31, ZR, 5'd0, 64'h0,         64'h4000, 1'b0, 1'b0, 1'b0, 57'h0,  1'b0, 1'b0},
    '{6'd31, DR, 5'd0, 64'h0,         64'h4000, 1'b0, 1'b0, 1'b0, 57'h0,  1'b0, 1'b0},
    '{6'd31, FL, 5'd0, 64'h0,         64'h4000, 1'b0, 1'b0, 1'b0, 57'h0,  1'b0, 1'b0},
    '{6'd31, ZR, 5'd0, 64'h0,         64'h5000, 1'b0, 1'b0, 1'b0, 57'h0,  1'b0, 1'b0},
    '{6'd31, 10'd100, 5'd0, 64'h0,    64'h5000, 1'b0, 1'b0, 1'b0, 57'h0,  1'b0, 1'b0},
    '{6'd30, FL, 5'd0, 64'h0,         64'h5000, 1'b0, 1'b0, 1'b0, 57'h0,  1'b0, 1'b0},
    '{6'd31, FL, 5'd0, 64'h0,         64'h5000, 1'b0, 1'b0, 1'b1, 57'hA0, 1'b0, 1'b0},
    '{6'd31, DR, 5'd0, 64'h0,         64'h5000, 1'b1, 1'b1, 1'b0, 57'h0,  1'b0, 1'b1}
  };

  // R1..R10 requirement map for the table above:
  // R1 rows 17,18,19  R2 rows 1,3,4  R3 rows 1,19  R4 rows 2,6  R5 rows 4,5
  // R6 rows 10,14,15  R7 rows 11,12,20  R8 rows 8,9
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [31:0] cmd_instr;
  logic [63:0] cmd_ra_val, cmd_rb_val;
  logic        cmd_user, xlate_fault;
  logic        busy, done, fault_dsi, fault_priv, mem_wr_en;
  logic [56:0] mem_wr_addr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cline_maint uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_instr(cmd_instr),
    .cmd_ra_val(cmd_ra_val), .cmd_rb_val(cmd_rb_val), .cmd_user(cmd_user),
    .xlate_fault(xlate_fault), .busy(busy), .done(done), .fault_dsi(fault_dsi),
    .fault_priv(fault_priv), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] p, input logic [9:0] x,
                                     input logic [4:0] rn);
    return {p, 5'd0, rn, 5'd2, x, 1'b0};
  endfunction

  // issue one command and watch it to completion
  task automatic run(input string req, input logic [31:0] ins,
                     input logic [63:0] ra, input logic [63:0] rb,
                     input logic usr, input logic xf,
                     input logic exp_wr, input logic [56:0] exp_wa,
                     input logic exp_dsi, input logic exp_prv, input bit poke);
    int n = 0;
    int wrc = 0;
    logic [56:0] wa = '0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_instr = ins; cmd_ra_val = ra; cmd_rb_val = rb;
    cmd_user = usr; xlate_fault = xf;
    @(negedge clk);
    cmd_valid = 1'b0; xlate_fault = 1'b0; cmd_user = 1'b0;
    n = 1;
    while (!done && n < 40) begin
      if (!busy) begin
        errors++; checks++;
        $display("FAIL R9 busy dropped before done: actual 0 expected 1");
      end
      if (mem_wr_en) begin wrc++; wa = mem_wr_addr; end
      if (poke && n == 3) begin
        cmd_valid = 1'b1; cmd_instr = mk(6'd31, ZR, 5'd0);
        cmd_rb_val = 64'h7000;
      end else begin
        cmd_valid = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    cmd_valid = 1'b0;
    chk(req, "write cycles", 64'(wrc), exp_wr ? 64'd4 : 64'd0);
    if (exp_wr) chk(req, "write address", 64'(wa), 64'(exp_wa));
    chk("R9", "latency", 64'(n), exp_wr ? 64'd6 : 64'd2);
    chk(req, "fault_dsi", 64'(fault_dsi), 64'(exp_dsi));
    chk(req, "fault_priv", 64'(fault_priv), 64'(exp_prv));
    chk("R9", "busy at done", 64'(busy), 64'd1);
    @(negedge clk);
    chk("R9", "done width", 64'(done), 64'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    cmd_valid = 1'b0; cmd_instr = '0; cmd_ra_val = '0; cmd_rb_val = '0;
    cmd_user = 1'b0; xlate_fault = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R10: outputs during reset
    chk("R10", "busy in reset", 64'(busy), 64'd0);
    chk("R10", "done in reset", 64'(done), 64'd0);
    chk("R10", "faults in reset", 64'({fault_dsi, fault_priv}), 64'd0);
    chk("R10", "wr in reset", 64'(mem_wr_en), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10: lines start invalid
    run("R10", mk(6'd31, FL, 5'd0), 64'h0, 64'h1000, 1'b0, 1'b0,
        1'b0, 57'h0, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      run($sformatf("vec%0d", i), mk(VEC[i].prim, VEC[i].xo, VEC[i].ran),
          VEC[i].ra, VEC[i].rb, VEC[i].usr, VEC[i].xf,
          VEC[i].wr, VEC[i].wa, VEC[i].dsi, VEC[i].prv, 1'b0);
    end

    // R9: command poked while busy is ignored
    run("R8", mk(6'd31, ZR, 5'd0), 64'h0, 64'h6000, 1'b0, 1'b0,
        1'b0, 57'h0, 1'b0, 1'b0, 1'b0);
    run("R3", mk(6'd31, FL, 5'd0), 64'h0, 64'h6000, 1'b0, 1'b0,
        1'b1, 57'hC0, 1'b0, 1'b0, 1'b1);
    run("R9", mk(6'd31, FL, 5'd0), 64'h0, 64'h7000, 1'b0, 1'b0,
        1'b0, 57'h0, 1'b0, 1'b0, 1'b0);

    // R10: reset clears a dirty line
    run("R8", mk(6'd31, ZR, 5'd0), 64'h0, 64'h8000, 1'b0, 1'b0,
        1'b0, 57'h0, 1'b0, 1'b0, 1'b0);
    do_reset();
    run("R10", mk(6'd31, FL, 5'd0), 64'h0, 64'h8000, 1'b0, 1'b0,
        1'b0, 57'h0, 1'b0, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule